// File: doc/BRIEF.md
# Regulator soft-start and powergood sequencer

This block sequences the start-up of a switching regulator that has a tracking linear regulator beside it. When enabled, it holds the reference DAC at its lowest code. That code is the start level, about 87% of the 750 mV target. It also keeps the switcher overcurrent threshold at half of nominal and waits for the comparator to report that the switcher output is above 80% of target. It then steps the 4-bit reference code up to the target code, one step every `STEP_TICKS` ticks of the timebase input. It returns the overcurrent threshold to nominal on the same cycle that the final code is reached.

Powergood is an active-high output that releases an external open-drain pull-down. It rises only when two conditions hold and a further `HOLD_TICKS` ticks pass with both still true: the reference sits at its target code, and the switcher output is reported above 95% of target. The linear-regulator current limit runs on its own. It stays at the reduced (60%) level while that regulator's good flag is low and is never used by powergood. Dropping the enable returns everything to its reset state.

The analog comparators, the DAC, the drivers and the current sensing are outside the block. It sees only their flags and drives only their codes. `tick` is a one-cycle timebase strobe. The defaults assume one tick per microsecond: 15 steps of 6 ticks give about 90 µs of ramp, and the hold is 45 µs.

Top module: `ssq_softstart_seq`

## Requirements
- R1: While `rst_n` is low, and while `en` is low after reset, `dac_code` is 0, `ocp_full` is 0, `lin_limit_full` is 0 and `pgood` is 0, whatever the other inputs do.
- R2: After `en` rises, `dac_code` stays 0 (the 650 mV start level) and `ocp_full` stays 0 (half-nominal threshold) until `sw_above80` is sampled high, even while `sw_above95` is high.
- R3: The ramp starts on the clock edge that samples `sw_above80` high. From then on, `dac_code` equals the number of ticks counted after that edge divided by `STEP_TICKS`, and it stops at 15 (the 750 mV target). Cycles without `tick` do not advance it.
- R4: `ocp_full` (1 = nominal threshold) rises on the same edge on which `dac_code` reaches 15, is 0 before that edge, and stays 1 until `en` falls.
- R5: `pgood` rises on the edge that counts the `HOLD_TICKS`-th tick. Counting begins on the first edge after one on which `dac_code` is 15 and `sw_above95` is high. `pgood` stays low at every earlier edge.
- R6: If `sw_above95` is sampled low while `pgood` is high or the hold is running, `pgood` is low after that edge. When the flag returns, the full `HOLD_TICKS` hold starts again from zero.
- R7: `lin_limit_full` (0 = 60% reduced limit, 1 = normal limit) follows `lin_good` one clock later while `en` is high, and is 0 while `en` is low.
- R8: `lin_good` has no effect on `pgood`, neither before powergood nor after it.
- R9: A low `en` clears all outputs on the next edge and restarts the sequence from the start level. A later enable repeats the full wait, ramp and hold timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| en | input | 1 | Sequencer enable |
| tick | input | 1 | One-cycle timebase strobe for the ramp and hold timers |
| sw_above80 | input | 1 | Switcher output above 80% of target |
| sw_above95 | input | 1 | Switcher output above 95% of target |
| lin_good | input | 1 | Linear-regulator output good |
| dac_code | output | DAC_W | Reference DAC code, 0 = start level, all ones = target |
| ocp_full | output | 1 | Switcher overcurrent threshold select, 0 = half, 1 = nominal |
| lin_limit_full | output | 1 | Linear current-limit select, 0 = reduced, 1 = normal |
| pgood | output | 1 | Powergood, 1 releases the open-drain pull-down |

## Verification
The ramp is driven with tick strobes on every cycle, every second cycle and every third cycle, and once with a burst of missing ticks in the middle. At every cycle the expected code is computed as counted ticks divided by the step size. This separates a timer that counts ticks from one that counts clocks, and it exposes an off-by-one in the step or in the overcurrent release. The 95% flag is tried in three ways: high before the ramp ends, raised only after the ramp, and pulsed low inside the hold. This tells a hold that waits for the target code apart from one that waits for the flag alone, and a restarting hold apart from a resuming one. The linear good flag is toggled before and after powergood, and the enable is dropped in the middle of a ramp, to show that the clamp and powergood stay independent and that the sequence restarts from the beginning.

// File: rtl/ssq_pkg.sv
package ssq_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_WAIT80,
    S_RAMP,
    S_WAITGOOD,
    S_PGDELAY,
    S_GOOD
  } seq_state_e;

endpackage

// File: rtl/ssq_tick_counter.sv
// Counts qualified ticks up to LIMIT and pulses done on the LIMIT-th one.
module ssq_tick_counter #(
  parameter int unsigned LIMIT = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  output logic done
);

  localparam int unsigned CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  assign done = run && (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (clr) begin
      cnt_d = '0;
    end else if (run) begin
      if (cnt_q == LAST) cnt_d = '0;
      else               cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R3: the count never passes its terminal value
  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

  // R9: a clear always leaves the counter at zero
  p_cnt_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0));

endmodule

// File: rtl/ssq_ref_dac.sv
// Reference code register: cleared to the start level, advanced one code per step.
module ssq_ref_dac #(
  parameter int unsigned DAC_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             step,
  output logic [DAC_W-1:0] code,
  output logic             near_top
);

  localparam logic [DAC_W-1:0] CODE_TOP = '1;
  localparam logic [DAC_W-1:0] CODE_PRE = CODE_TOP - 1'b1;

  logic [DAC_W-1:0] code_q;
  logic [DAC_W-1:0] code_d;

  assign code     = code_q;
  assign near_top = (code_q == CODE_PRE);

  always_comb begin
    code_d = code_q;
    if (clr) begin
      code_d = '0;
    end else if (step && (code_q != CODE_TOP)) begin
      code_d = code_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) code_q <= '0;
    else        code_q <= code_d;
  end

  // R3: without a step or clear the code holds
  p_code_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !step) |=> $stable(code_q));

  // R3: a step moves the code up by exactly one
  p_code_inc_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && step && code_q != CODE_TOP) |=> (code_q == $past(code_q) + 1'b1));

endmodule

// File: rtl/ssq_lin_clamp.sv
// Linear-regulator current-limit select, kept apart from the switcher path.
module ssq_lin_clamp (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic lin_good,
  output logic lin_full
);

  logic full_q;
  logic full_d;

  assign lin_full = full_q;

  always_comb begin
    full_d = 1'b0;
    if (en) full_d = lin_good;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) full_q <= 1'b0;
    else        full_q <= full_d;
  end

  // R7: a good flag under enable releases the clamp next cycle
  p_lin_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (en && lin_good) |=> full_q);

  // R7: a low good flag restores the reduced limit next cycle
  p_lin_reduce_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!lin_good) |=> !full_q);

endmodule

// File: rtl/ssq_softstart_seq.sv
module ssq_softstart_seq #(
  parameter int unsigned DAC_W      = 4,
  parameter int unsigned STEP_TICKS = 6,
  parameter int unsigned HOLD_TICKS = 45
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             tick,
  input  logic             sw_above80,
  input  logic             sw_above95,
  input  logic             lin_good,
  output logic [DAC_W-1:0] dac_code,
  output logic             ocp_full,
  output logic             lin_limit_full,
  output logic             pgood
);

  import ssq_pkg::*;

  localparam logic [DAC_W-1:0] CODE_TOP = '1;

  seq_state_e state_q;
  seq_state_e state_d;
  logic       ocp_q;
  logic       ocp_d;
  logic       pg_q;
  logic       pg_d;

  logic ramp_clr;
  logic ramp_run;
  logic step_done;
  logic hold_clr;
  logic hold_run;
  logic hold_done;
  logic dac_clr;
  logic near_top;

  // Ramp step timer: runs only in RAMP
  assign ramp_clr = !en || (state_q != S_RAMP);
  assign ramp_run = en && (state_q == S_RAMP) && tick;

  ssq_tick_counter #(.LIMIT(STEP_TICKS)) u_step_tmr (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (ramp_clr),
    .run   (ramp_run),
    .done  (step_done)
  );

  // Powergood hold timer: runs only in PG_DELAY with the 95% flag up
  assign hold_clr = !en || (state_q != S_PGDELAY);
  assign hold_run = en && (state_q == S_PGDELAY) && sw_above95 && tick;

  ssq_tick_counter #(.LIMIT(HOLD_TICKS)) u_hold_tmr (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (hold_clr),
    .run   (hold_run),
    .done  (hold_done)
  );

  assign dac_clr = !en || (state_q == S_IDLE);

  ssq_ref_dac #(.DAC_W(DAC_W)) u_ref (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (dac_clr),
    .step     (step_done),
    .code     (dac_code),
    .near_top (near_top)
  );

  ssq_lin_clamp u_lin (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .lin_good (lin_good),
    .lin_full (lin_limit_full)
  );

  // Next-state logic
  always_comb begin
    state_d = state_q;
    if (!en) begin
      state_d = S_IDLE;
    end else begin
      unique case (state_q)
        S_IDLE:     state_d = S_WAIT80;
        S_WAIT80:   if (sw_above80) state_d = S_RAMP;
        S_RAMP:     if (step_done && near_top) state_d = S_WAITGOOD;
        S_WAITGOOD: if (sw_above95) state_d = S_PGDELAY;
        S_PGDELAY: begin
          if (!sw_above95)    state_d = S_WAITGOOD;
          else if (hold_done) state_d = S_GOOD;
        end
        S_GOOD:     if (!sw_above95) state_d = S_WAITGOOD;
        default:    state_d = S_IDLE;
      endcase
    end
  end

  // Registered output decode from the next state
  always_comb begin
    ocp_d = (state_d == S_WAITGOOD) || (state_d == S_PGDELAY) || (state_d == S_GOOD);
    pg_d  = (state_d == S_GOOD);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      ocp_q   <= 1'b0;
      pg_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      ocp_q   <= ocp_d;
      pg_q    <= pg_d;
    end
  end

  assign ocp_full = ocp_q;
  assign pgood    = pg_q;

  // R2: no ramp while waiting for the 80% flag
  p_wait_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_WAIT80) |-> (dac_code == '0));

  // R4: nominal threshold only with the reference at target
  p_ocp_at_top_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ocp_full |-> (dac_code == CODE_TOP));

  // R5: powergood needs target code and nominal threshold
  p_pg_needs_top_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pgood |-> (dac_code == CODE_TOP && ocp_full));

  // R5: powergood rises only with the 95% flag seen
  p_pg_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pgood) |-> $past(sw_above95));

  // R6: a low 95% flag removes powergood on the next edge
  p_pg_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_above95) |=> !pgood);

  // R9: disable clears every output on the next edge
  p_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!en) |=> (dac_code == '0 && !ocp_full && !pgood && !lin_limit_full));

endmodule

// File: tb/ssq_softstart_seq_tb_top.sv
module ssq_softstart_seq_tb_top;

  localparam int STEP = 3;
  localparam int HOLD = 4;
  localparam int DW   = 4;
  localparam int TOP  = 15;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          en;
  logic          tick;
  logic          sw_above80;
  logic          sw_above95;
  logic          lin_good;
  logic [DW-1:0] dac_code;
  logic          ocp_full;
  logic          lin_limit_full;
  logic          pgood;

  int checks   = 0;
  int failures = 0;

  always #4 clk = ~clk;

  ssq_softstart_seq #(
    .DAC_W      (DW),
    .STEP_TICKS (STEP),
    .HOLD_TICKS (HOLD)
  ) dut_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .en             (en),
    .tick           (tick),
    .sw_above80     (sw_above80),
    .sw_above95     (sw_above95),
    .lin_good       (lin_good),
    .dac_code       (dac_code),
    .ocp_full       (ocp_full),
    .lin_limit_full (lin_limit_full),
    .pgood          (pgood)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check_off(input string req);
    chk(req, "dac_code", int'(dac_code), 0);
    chk(req, "ocp_full", int'(ocp_full), 0);
    chk(req, "lin_limit_full", int'(lin_limit_full), 0);
    chk(req, "pgood", int'(pgood), 0);
  endtask

  function automatic logic pat(input int n, input int p, input int pa, input int pl);
    if (pl > 0 && n >= pa && n < pa + pl) return 1'b0;
    return ((n % p) == 0);
  endfunction

  // Enable already high and sequencer in the wait state; runs to the target code.
  task automatic ramp_phase(input int p, input int pa, input int pl, input logic sw95);
    int ticks;
    int exp_code;
    ticks = 0;
    sw_above95 = sw95;
    repeat (3) begin
      cyc();
      chk("R2", "code before 80% flag", int'(dac_code), 0);
      chk("R2", "ocp before 80% flag", int'(ocp_full), 0);
      chk("R5", "pgood before ramp", int'(pgood), 0);
    end
    sw_above80 = 1'b1;
    tick = pat(1, p, pa, pl);
    for (int n = 1; n < 2000; n++) begin
      @(posedge clk);
      if (n >= 2 && tick) ticks++;
      @(negedge clk);
      exp_code = ticks / STEP;
      if (exp_code > TOP) exp_code = TOP;
      chk("R3", "ramp code", int'(dac_code), exp_code);
      chk("R4", "ocp release", int'(ocp_full), (ticks >= TOP * STEP) ? 1 : 0);
      if (ticks >= TOP * STEP) break;
      tick = pat(n + 1, p, pa, pl);
    end
    tick = 1'b1;
  endtask

  // Hold window with a tick every cycle; powergood expected on edge HOLD+1.
  task automatic hold_phase(input string req);
    for (int m = 1; m <= HOLD + 1; m++) begin
      cyc();
      chk(req, "pgood hold", int'(pgood), (m >= HOLD + 1) ? 1 : 0);
    end
  endtask

  task automatic disable_all();
    en = 1'b0;
    cyc();
    check_off("R9");
    sw_above80 = 1'b0;
    sw_above95 = 1'b0;
    lin_good   = 1'b0;
    cyc();
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; en = 1'b0; tick = 1'b1;
    sw_above80 = 1'b1; sw_above95 = 1'b1; lin_good = 1'b1;
    repeat (3) cyc();
    check_off("R1");
    rst_n = 1'b1;
    repeat (3) begin
      cyc();
      check_off("R1");
      chk("R7", "clamp while disabled", int'(lin_limit_full), 0);
    end
    sw_above80 = 1'b0; sw_above95 = 1'b0; lin_good = 1'b0;
    cyc();

    // Tick rate sweep, 95% flag already high during the ramp
    for (int p = 1; p <= 3; p++) begin
      en = 1'b1;
      cyc();
      ramp_phase(p, 0, 0, 1'b1);
      hold_phase("R5");
      lin_good = 1'b1;
      cyc();
      chk("R7", "clamp released", int'(lin_limit_full), 1);
      chk("R8", "pgood with lin good", int'(pgood), 1);
      lin_good = 1'b0;
      cyc();
      chk("R7", "clamp reduced", int'(lin_limit_full), 0);
      chk("R8", "pgood with lin low", int'(pgood), 1);
      disable_all();
    end

    // Burst of missing ticks in the middle of the ramp
    en = 1'b1;
    cyc();
    ramp_phase(1, 10, 7, 1'b1);
    hold_phase("R5");
    disable_all();

    // 95% flag only after the ramp; drop and glitch cases
    en = 1'b1;
    lin_good = 1'b1;
    cyc();
    ramp_phase(1, 0, 0, 1'b0);
    repeat (6) begin
      cyc();
      chk("R8", "pgood ignores lin good", int'(pgood), 0);
      chk("R7", "clamp follows good", int'(lin_limit_full), 1);
    end
    sw_above95 = 1'b1;
    hold_phase("R5");
    sw_above95 = 1'b0;
    cyc();
    chk("R6", "pgood after drop", int'(pgood), 0);
    chk("R4", "ocp stays nominal", int'(ocp_full), 1);
    sw_above95 = 1'b1;
    hold_phase("R6");
    sw_above95 = 1'b0;
    cyc();
    chk("R6", "pgood after second drop", int'(pgood), 0);
    sw_above95 = 1'b1;
    repeat (HOLD) begin
      cyc();
      chk("R6", "pgood inside hold", int'(pgood), 0);
    end
    sw_above95 = 1'b0;
    cyc();
    chk("R6", "pgood after glitch", int'(pgood), 0);
    sw_above95 = 1'b1;
    hold_phase("R6");
    disable_all();

    // Abort mid-ramp and restart from the start level
    en = 1'b1;
    cyc();
    sw_above80 = 1'b1;
    repeat (2 * STEP + 2) cyc();
    chk("R3", "code mid ramp", int'(dac_code), 2);
    en = 1'b0;
    cyc();
    check_off("R9");
    sw_above80 = 1'b0;
    en = 1'b1;
    cyc();
    ramp_phase(2, 0, 0, 1'b1);
    hold_phase("R9");
    disable_all();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule